// File: doc/BRIEF.md
# Unserviced-NMI Service Timer

This block measures how long a pending non-maskable interrupt stays unanswered. While the pending input is high, a 16-bit counter advances once per clock. When the count reaches a programmable limit, the block emits a one-clock reset request and the count returns to zero. Software may shorten the limit, but only while a write-unlock input is high. The live count and the limit can both be read back at any time.

Four debug-state inputs decide whether the counter may advance:

- Real-time single-step always freezes the count.
- Either free-running mode overrides a CPU halt, so counting continues.
- A plain halt freezes the count.

Limit writes are compared against the live count. If a write equals the count, it forces an immediate request. If a write is below the count, the counter must wrap past the maximum before the new limit can be reached.

Top module: `nmi_svc_timer`

## Requirements
- R1: After synchronous reset the limit reads 0xFFFF, the count reads 0 and the request output is low.
- R2: While pend_i is high and counting is not suspended, the count rises by exactly one per clock. One clock after pend_i is sampled low, the count reads 0 and no request is raised.
- R3: When the counter is advancing and its current value equals the limit, the request output is high for the next cycle only and the count reads 0 in that cycle.
- R4: A limit write is accepted when wr_en_i and wr_unlock_i are both high. If pend_i is high and the written data equals the current count, the next cycle shows the request high and the count at 0. This holds even while counting is suspended.
- R5: If a limit below the current count is written, no request follows until the count has wrapped and climbed to the new limit. The request then fires as in R3.
- R6: The count steps from 0xFFFF to 0x0000 without a request whenever the limit is not 0xFFFF.
- R7: A limit write with wr_unlock_i low is ignored, and the limit reads its previous value afterwards.
- R8: With dbg_halt_i high and all three mode inputs low, the count holds its value.
- R9: With dbg_halt_i high, raising either dbg_free_i or dbg_rtfree_i lets the count advance again.
- R10: While dbg_rtss_i is high, the count holds whatever the other debug inputs are.
- R11: A forced match and a count-reached match in the same cycle produce a single one-cycle request, and the count then reads 0.
- R12: An accepted limit value appears on limit_o in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 1 | NMI pending: counter enable |
| wr_en_i | input | 1 | Limit write strobe |
| wr_unlock_i | input | 1 | Write-protect release |
| wr_data_i | input | 16 | Limit write data |
| dbg_halt_i | input | 1 | CPU halted by debugger |
| dbg_free_i | input | 1 | Free-run mode |
| dbg_rtss_i | input | 1 | Real-time single-step mode |
| dbg_rtfree_i | input | 1 | Real-time free-run mode |
| rst_req_o | output | 1 | One-cycle reset request |
| count_o | output | 16 | Live count |
| limit_o | output | 16 | Current limit |

## Verification
Every result lands exactly one clock after the edge that samples its cause: count updates, the request pulse, the zeroing of the count and the new limit value. No result takes two cycles. The bench changes inputs one time unit after a rising edge and reads outputs one time unit after the next rising edge. Each check therefore sees the effect of exactly the stimulus applied in the previous cycle. The wrap scenario steps cycle by cycle to 0xFFFF, counting any stray request on the way, before it checks the wrap and the late match.

// File: rtl/nst_pkg.sv
package nst_pkg;
  // Counter gating decision derived from the debug-state inputs
  typedef enum logic [1:0] {
    GATE_RUN  = 2'd0,
    GATE_HALT = 2'd1,
    GATE_STEP = 2'd2
  } gate_e;
endpackage

// File: rtl/nst_suspend_gate.sv
module nst_suspend_gate
  import nst_pkg::*;
(
  input  logic  halt_i,
  input  logic  free_i,
  input  logic  rtss_i,
  input  logic  rtfree_i,
  output gate_e gate_o,
  output logic  run_o
);
  // Single-step wins over everything; either free mode overrides a halt.
  always_comb begin
    if (rtss_i)                gate_o = GATE_STEP;
    else if (free_i || rtfree_i) gate_o = GATE_RUN;
    else if (halt_i)           gate_o = GATE_HALT;
    else                       gate_o = GATE_RUN;
  end

  assign run_o = (gate_o == GATE_RUN);
endmodule

// File: rtl/nst_limit_reg.sv
module nst_limit_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic         wr_unlock_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_acc_o,
  output logic [W-1:0] limit_o
);
  localparam logic [W-1:0] LIMIT_RST = {W{1'b1}};

  assign wr_acc_o = wr_en_i & wr_unlock_i;

  always_ff @(posedge clk) begin
    if (rst)           limit_o <= LIMIT_RST;
    else if (wr_acc_o) limit_o <= wr_data_i;
  end
endmodule

// File: rtl/nst_count_core.sv
module nst_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pend_i,
  input  logic         run_i,
  input  logic         wr_acc_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         req_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         advance;
  logic         hit_reach;
  logic         hit_force;
  logic         fire;
  logic [W-1:0] count_nx;

  always_comb begin
    advance   = pend_i & run_i;
    hit_reach = advance && (count_o == limit_i);
    hit_force = pend_i && wr_acc_i && (wr_data_i == count_o);
    fire      = hit_reach | hit_force;
    if (!pend_i)      count_nx = '0;
    else if (fire)    count_nx = '0;
    else if (advance) count_nx = count_o + ONE; // natural wrap at the top
    else              count_nx = count_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      req_o   <= 1'b0;
    end else begin
      count_o <= count_nx;
      req_o   <= fire;
    end
  end
endmodule

// File: rtl/nmi_svc_timer.sv
module nmi_svc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pend_i,
  input  logic         wr_en_i,
  input  logic         wr_unlock_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         dbg_halt_i,
  input  logic         dbg_free_i,
  input  logic         dbg_rtss_i,
  input  logic         dbg_rtfree_i,
  output logic         rst_req_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] limit_o
);
  import nst_pkg::*;

  gate_e gate;
  logic  run;
  logic  wr_acc;

  nst_suspend_gate u_gate (
    .halt_i   (dbg_halt_i),
    .free_i   (dbg_free_i),
    .rtss_i   (dbg_rtss_i),
    .rtfree_i (dbg_rtfree_i),
    .gate_o   (gate),
    .run_o    (run)
  );

  nst_limit_reg #(.W(W)) u_limit (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .wr_unlock_i (wr_unlock_i),
    .wr_data_i   (wr_data_i),
    .wr_acc_o    (wr_acc),
    .limit_o     (limit_o)
  );

  nst_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend_i),
    .run_i     (run),
    .wr_acc_i  (wr_acc),
    .wr_data_i (wr_data_i),
    .limit_i   (limit_o),
    .count_o   (count_o),
    .req_o     (rst_req_o)
  );
endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         pend_i,
  input logic         wr_en_i,
  input logic         wr_unlock_i,
  input logic [W-1:0] wr_data_i,
  input logic         dbg_halt_i,
  input logic         dbg_free_i,
  input logic         dbg_rtss_i,
  input logic         dbg_rtfree_i,
  input logic         rst_req_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] limit_o
);
  logic wr_ok;
  logic may_run;
  assign wr_ok   = wr_en_i && wr_unlock_i;
  assign may_run = !dbg_rtss_i && (dbg_free_i || dbg_rtfree_i || !dbg_halt_i);

  // R2: idle clears the count and never requests
  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !pend_i |=> (count_o == '0) && !rst_req_o);

  // R2: one step per clock when running below the limit
  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_i && may_run && !wr_ok && count_o != limit_o)
      |=> count_o == $past(count_o) + 1'b1);

  // R3 / R11: a request always coincides with a zero count
  assert_req_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> count_o == '0);

  // R4: write equal to the live count forces a request
  assert_forced_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_i && wr_ok && wr_data_i == count_o) |=> rst_req_o && count_o == '0);

  // R7: locked writes leave the limit alone
  assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(limit_o));

  // R8: plain halt freezes the count
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_i && dbg_halt_i && !dbg_free_i && !dbg_rtfree_i && !dbg_rtss_i && !wr_ok)
      |=> $stable(count_o));

  // R10: single-step freezes the count
  assert_step_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_i && dbg_rtss_i && !wr_ok) |=> $stable(count_o));

  // R12: accepted value visible next cycle
  assert_readback_R12: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> limit_o == $past(wr_data_i));
endmodule

bind nmi_svc_timer nst_checker #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pend_i       (pend_i),
  .wr_en_i      (wr_en_i),
  .wr_unlock_i  (wr_unlock_i),
  .wr_data_i    (wr_data_i),
  .dbg_halt_i   (dbg_halt_i),
  .dbg_free_i   (dbg_free_i),
  .dbg_rtss_i   (dbg_rtss_i),
  .dbg_rtfree_i (dbg_rtfree_i),
  .rst_req_o    (rst_req_o),
  .count_o      (count_o),
  .limit_o      (limit_o)
);

// File: tb/sim_nmi_svc_timer.sv
module sim_nmi_svc_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pend_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_unlock_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        dbg_halt_i = 1'b0;
  logic        dbg_free_i = 1'b0;
  logic        dbg_rtss_i = 1'b0;
  logic        dbg_rtfree_i = 1'b0;
  logic        rst_req_o;
  logic [15:0] count_o;
  logic [15:0] limit_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  nmi_svc_timer u0 (
    .clk(clk), .rst(rst), .pend_i(pend_i), .wr_en_i(wr_en_i),
    .wr_unlock_i(wr_unlock_i), .wr_data_i(wr_data_i),
    .dbg_halt_i(dbg_halt_i), .dbg_free_i(dbg_free_i),
    .dbg_rtss_i(dbg_rtss_i), .dbg_rtfree_i(dbg_rtfree_i),
    .rst_req_o(rst_req_o), .count_o(count_o), .limit_o(limit_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic write_lim(input logic [15:0] v, input logic unlock);
    wr_en_i = 1'b1; wr_unlock_i = unlock; wr_data_i = v;
    step();
    wr_en_i = 1'b0; wr_unlock_i = 1'b0;
  endtask

  task automatic idle();
    pend_i = 1'b0;
    dbg_halt_i = 0; dbg_free_i = 0; dbg_rtss_i = 0; dbg_rtfree_i = 0;
    step();
  endtask

  task automatic t_reset();
    check("R1 limit", limit_o, 16'hFFFF);
    check("R1 count", count_o, 0);
    check("R1 req", rst_req_o, 0);
  endtask

  task automatic t_count();
    idle();
    write_lim(16'd20, 1'b1);
    check("R12 limit readback", limit_o, 20);
    pend_i = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check("R2 count after 5", count_o, 5);
    pend_i = 1'b0;
    step();
    check("R2 cleared when idle", count_o, 0);
    check("R2 no req when idle", rst_req_o, 0);
  endtask

  task automatic t_reach();
    idle();
    write_lim(16'd5, 1'b1);
    pend_i = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check("R3 at limit", count_o, 5);
    check("R3 no early req", rst_req_o, 0);
    step();
    check("R3 req pulse", rst_req_o, 1);
    check("R3 count zero", count_o, 0);
    step();
    check("R3 pulse one cycle", rst_req_o, 0);
    check("R3 restart", count_o, 1);
  endtask

  task automatic t_forced();
    idle();
    write_lim(16'd100, 1'b1);
    pend_i = 1'b1;
    for (int i = 0; i < 7; i++) step();
    check("R4 pre count", count_o, 7);
    dbg_halt_i = 1'b1;   // forced match still applies while suspended
    write_lim(16'd7, 1'b1);
    check("R4 forced req", rst_req_o, 1);
    check("R4 forced clear", count_o, 0);
    check("R12 forced limit", limit_o, 7);
    dbg_halt_i = 1'b0;
  endtask

  task automatic t_locked();
    idle();
    write_lim(16'd30, 1'b1);
    write_lim(16'd3, 1'b0);
    check("R7 locked write ignored", limit_o, 30);
    check("R7 no req", rst_req_o, 0);
  endtask

  task automatic t_below();
    int pulses = 0;
    int guard  = 0;
    idle();
    write_lim(16'd200, 1'b1);
    pend_i = 1'b1;
    for (int i = 0; i < 150; i++) step();
    check("R5 pre count", count_o, 150);
    write_lim(16'd100, 1'b1);
    if (rst_req_o) pulses++;
    while (count_o != 16'hFFFF && guard < 70000) begin
      step();
      guard++;
      if (rst_req_o) pulses++;
    end
    check("R5 no req before wrap", pulses, 0);
    check("R5 reached top", count_o, 16'hFFFF);
    step();
    check("R6 wrap to zero", count_o, 0);
    check("R6 no req on wrap", rst_req_o, 0);
    for (int i = 0; i < 100; i++) step();
    check("R5 at new limit", count_o, 100);
    step();
    check("R5 late req", rst_req_o, 1);
    check("R5 late clear", count_o, 0);
  endtask

  task automatic t_debug();
    idle();
    write_lim(16'hFFFF, 1'b1);
    pend_i = 1'b1;
    for (int i = 0; i < 4; i++) step();
    dbg_halt_i = 1'b1;
    for (int i = 0; i < 3; i++) step();
    check("R8 halt holds", count_o, 4);
    dbg_free_i = 1'b1;
    for (int i = 0; i < 2; i++) step();
    check("R9 free overrides halt", count_o, 6);
    dbg_free_i = 1'b0; dbg_rtfree_i = 1'b1;
    for (int i = 0; i < 2; i++) step();
    check("R9 rt free overrides halt", count_o, 8);
    dbg_rtss_i = 1'b1;
    for (int i = 0; i < 3; i++) step();
    check("R10 single-step holds with rtfree", count_o, 8);
    dbg_rtfree_i = 1'b0; dbg_halt_i = 1'b0;
    for (int i = 0; i < 3; i++) step();
    check("R10 single-step holds alone", count_o, 8);
    dbg_rtss_i = 1'b0;
    step();
    check("R2 resumes", count_o, 9);
  endtask

  task automatic t_coincide();
    idle();
    write_lim(16'd4, 1'b1);
    pend_i = 1'b1;
    for (int i = 0; i < 4; i++) step();
    check("R11 pre count", count_o, 4);
    write_lim(16'd4, 1'b1);
    check("R11 one req", rst_req_o, 1);
    check("R11 count zero", count_o, 0);
    step();
    check("R11 pulse ends", rst_req_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_count();
    t_reach();
    t_forced();
    t_locked();
    t_below();
    t_debug();
    t_coincide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule